// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is an SPI master with a small word-addressed register port. Software loads words into a transmit FIFO by writing the data register. It drains received words from a receive FIFO by reading that same register. A serial engine takes words from the transmit FIFO one at a time and shifts each one out MSB first on `mosi_o`. At the same time it gathers one word from `miso_i` and pushes it into the receive FIFO.

Each FIFO holds a fixed number of bytes (16 by default), so its depth in words depends on the programmed word size of 8, 16 or 32 bits. The following are all programmable:
- clock idle level;
- the edge on which output data changes;
- the input sample point;
- a 9-bit baud divisor.

An optional hardware slave-select output stays low while there is work queued or shifting. A sticky overflow flag records received words that were lost because the receive FIFO was full. Every register is reachable through a raw, a set (OR-in) and a clear (AND-NOT) alias.

Top module: `spi_fifo_master`

## Requirements
- R1: `reg_addr_i[3:2]` selects the register: 0 control, 1 status, 2 data, 3 baud. `reg_addr_i[1:0]` selects the alias: 1 clears the written ones, 2 ORs in the written ones, and 0 or 3 is a raw write. Reads return the register through any alias. Baud keeps only its low 9 bits.
- R2: The control bit positions are fixed: 15 module on, 5 master run, 6 clock idle level, 8 clock edge select, 9 sample point, 11:10 word size (0 = 8, 1 = 16, 2 or 3 = 32 bits), 16 deep FIFO, 28 hardware slave-select. All control bits are 0 after reset.
- R3: Each word shifts MSB first. Every transmitted word yields exactly one received word, made of the low N bits of the serial input, in the receive FIFO. Transmit bits above the word size are ignored.
- R4: Each bit lasts 2×(baud+1) clocks. With hardware slave-select on, one isolated word holds `ss_no` low for 1 + 2·N·(baud+1) clocks, counted from the write that queues it.
- R5: `sclk_o` rests at the idle level (control bit 6) and makes exactly 2·N transitions per word. Edge select 1 holds the clock idle for the first half of each bit; edge select 0 drives it active for the first half.
- R6: Sample point 0 captures `miso_i` at the middle of each bit. Sample point 1 captures it at the end of the bit.
- R7: With the deep-FIFO bit set, each FIFO holds 16, 8 or 4 words for 8-, 16- or 32-bit words. With that bit clear, each FIFO holds 1 word.
- R8: Status bits 20:16 give the transmit FIFO fill level and bits 28:24 the receive FIFO fill level. Status is all zero after reset.
- R9: A data write while the transmit FIFO is full is discarded. Queued words leave in write order.
- R10: A data read while the receive FIFO is empty returns 0 and changes no state.
- R11: Status bit 6 sets when a finished word finds the receive FIFO full; that word is dropped. The bit clears only when a 1 is written to bit 6 through the status clear alias.
- R12: Clearing the module-on bit stops the engine, returns `sclk_o` to the idle level and empties both FIFOs. All control, baud and mode bits keep their values.
- R13: With hardware slave-select on, `ss_no` is low while the transmit FIFO is non-empty or a word is shifting. It rises only once both are done. With it off, `ss_no` stays high.
- R14: With the master-run bit clear, queued words stay in the transmit FIFO and the serial clock does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register select [3:2] and alias select [1:0] |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (pops the receive FIFO on a data read) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 1 | Hardware slave-select, active low |

## Verification
The assertions assume that the word size, baud divisor and clock-mode bits stay fixed while a word is shifting or words are queued. They also assume that a read and a write are never strobed in the same cycle. Under those assumptions the FIFO level, the overflow flag and the slave-select line can be related cycle by cycle.

The stimulus respects these assumptions. The bench changes the configuration only after clearing the module-on bit with the engine idle. It issues one register access at a time, and it drives `miso_i` either from `mosi_o` as a loopback or from the serial clock's active phase, so the expected received word follows from the requirements alone.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int CTRL_ON  = 15;
  localparam int CTRL_MST = 5;
  localparam int CTRL_CKP = 6;
  localparam int CTRL_CKE = 8;
  localparam int CTRL_SMP = 9;
  localparam int CTRL_SZ  = 10;
  localparam int CTRL_ENH = 16;
  localparam int CTRL_HSS = 28;

  localparam int STAT_OVF = 6;
  localparam int STAT_TXL = 16;
  localparam int STAT_RXL = 24;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0, REG_STAT = 2'd1, REG_DATA = 2'd2, REG_BAUD = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    AL_RAW = 2'd0, AL_CLR = 2'd1, AL_SET = 2'd2, AL_RAW_ALT = 2'd3
  } alias_e;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_e;

  function automatic logic [31:0] apply_alias(alias_e a, logic [31:0] old_v, logic [31:0] wd);
    case (a)
      AL_SET:  return old_v | wd;
      AL_CLR:  return old_v & ~wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [LW-1:0] cap_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = cnt_q >= cap_i;
  assign empty_o = cnt_q == '0;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
    end
  end

  // R9: a push into a full FIFO leaves the level untouched
  p_full_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(level_o));
  // R10: a pop from an empty FIFO leaves it empty
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> (level_o == '0));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BAUD_W = 9,
  localparam int HALF_W = $clog2(2 * DATA_W),
  localparam int SH_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              go_i,
  input  logic [1:0]        size_i,
  input  logic              ckp_i,
  input  logic              cke_i,
  input  logic              smp_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  eng_state_e        state_q, state_d;
  logic [BAUD_W-1:0] div_q;
  logic [HALF_W-1:0] half_q, half_d, last_half;
  logic [DATA_W-1:0] tx_q, rx_q, rx_next;
  logic [SH_W-1:0]   nbits;
  logic              sclk_q, sclk_d, tick, is_last, sample, start;

  always_comb begin
    case (size_i)
      2'd0:    nbits = SH_W'(8);
      2'd1:    nbits = SH_W'(16);
      default: nbits = SH_W'(DATA_W);
    endcase
    last_half = HALF_W'(2 * nbits - 1);
    tick      = (state_q == ENG_SHIFT) && (div_q == baud_i);
    is_last   = half_q == last_half;
    sample    = smp_i ? half_q[0] : ~half_q[0];
    start     = en_i && (state_q == ENG_IDLE) && go_i && tx_valid_i;
    state_d   = state_q;
    half_d    = half_q;
    if (!en_i) begin
      state_d = ENG_IDLE;
    end else if (start) begin
      state_d = ENG_SHIFT;
      half_d  = '0;
    end else if (tick) begin
      if (is_last) state_d = ENG_IDLE;
      else         half_d  = half_q + 1'b1;
    end
    // clock follows the next half so it lines up with the data register
    sclk_d = (state_d == ENG_SHIFT) ? (ckp_i ^ (cke_i ? half_d[0] : ~half_d[0])) : ckp_i;
  end

  assign rx_next   = {rx_q[DATA_W-2:0], miso_i};
  assign rx_push_o = en_i && tick && is_last;
  assign rx_data_o = smp_i ? rx_next : rx_q;
  assign tx_pop_o  = start;
  assign busy_o    = state_q == ENG_SHIFT;
  assign mosi_o    = busy_o && tx_q[DATA_W-1];
  assign sclk_o    = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      half_q  <= '0;
      div_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
      sclk_q  <= sclk_d;
      if (!en_i) begin
        div_q <= '0;
      end else if (start) begin
        div_q <= '0;
        tx_q  <= tx_data_i << (SH_W'(DATA_W) - nbits);
        rx_q  <= '0;
      end else if (state_q == ENG_SHIFT) begin
        if (tick) begin
          div_q <= '0;
          if (sample) rx_q <= rx_next;
          if (half_q[0] && !is_last) tx_q <= tx_q << 1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  // R12: disabling parks the clock at the idle level
  p_idle_level_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(ckp_i)) && !busy_o);
  // R3: a received word is delivered exactly when its transfer ends
  p_word_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |=> !busy_o);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_ctl_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  parameter int DATA_W     = 32,
  parameter int BAUD_W     = 9,
  localparam int LVL_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        ss_no
);
  logic [31:0]       ctrl_q;
  logic [BAUD_W-1:0] baud_q;
  logic              ovf_q, ovf_clr;
  reg_sel_e          sel;
  alias_e            al;
  logic              raw_al, on, flush;
  logic [1:0]        bytes_log;
  logic [LVL_W-1:0]  cap, tx_lvl, rx_lvl;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty, busy;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic [31:0]       status;

  assign sel    = reg_sel_e'(reg_addr_i[3:2]);
  assign al     = alias_e'(reg_addr_i[1:0]);
  assign raw_al = (al == AL_RAW) || (al == AL_RAW_ALT);
  assign on     = ctrl_q[CTRL_ON];
  assign flush  = !on;

  assign bytes_log = (ctrl_q[CTRL_SZ+:2] == 2'd0) ? 2'd0 :
                     (ctrl_q[CTRL_SZ+:2] == 2'd1) ? 2'd1 : 2'd2;
  assign cap = ctrl_q[CTRL_ENH] ? LVL_W'(FIFO_BYTES >> bytes_log) : LVL_W'(1);

  assign tx_push = reg_wr_i && (sel == REG_DATA) && raw_al;
  assign rx_pop  = reg_rd_i && (sel == REG_DATA) && raw_al;
  assign ovf_clr = reg_wr_i && (sel == REG_STAT) && (al == AL_CLR) && reg_wdata_i[STAT_OVF];

  spi_fifo #(.DEPTH(FIFO_BYTES), .W(DATA_W)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .cap_i(cap),
    .push_i(tx_push), .wdata_i(reg_wdata_i[DATA_W-1:0]), .pop_i(tx_pop),
    .rdata_o(tx_head), .level_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_fifo #(.DEPTH(FIFO_BYTES), .W(DATA_W)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .cap_i(cap),
    .push_i(rx_push), .wdata_i(rx_word), .pop_i(rx_pop),
    .rdata_o(rx_head), .level_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_shifter #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) u_shift (
    .clk_i, .rst_ni, .en_i(on), .go_i(ctrl_q[CTRL_MST]),
    .size_i(ctrl_q[CTRL_SZ+:2]), .ckp_i(ctrl_q[CTRL_CKP]),
    .cke_i(ctrl_q[CTRL_CKE]), .smp_i(ctrl_q[CTRL_SMP]), .baud_i(baud_q),
    .tx_valid_i(!tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_word), .busy_o(busy),
    .sclk_o, .mosi_o, .miso_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      baud_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (reg_wr_i && sel == REG_CTRL) ctrl_q <= apply_alias(al, ctrl_q, reg_wdata_i);
      if (reg_wr_i && sel == REG_BAUD)
        baud_q <= BAUD_W'(apply_alias(al, 32'(baud_q), reg_wdata_i));
      if (rx_push && rx_full) ovf_q <= 1'b1;
      else if (ovf_clr)       ovf_q <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[STAT_TXL +: LVL_W] = tx_lvl;
    status[STAT_RXL +: LVL_W] = rx_lvl;
    status[STAT_OVF] = ovf_q;
    case (sel)
      REG_CTRL: reg_rdata_o = ctrl_q;
      REG_STAT: reg_rdata_o = status;
      REG_DATA: reg_rdata_o = rx_empty ? '0 : 32'(rx_head);
      default:  reg_rdata_o = 32'(baud_q);
    endcase
  end

  assign ss_no = !(ctrl_q[CTRL_HSS] && on && (busy || !tx_empty));

  // R11: flag holds until an explicit clear
  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R11: flag only rises on a lost word
  p_ovf_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(rx_push && rx_full));
  // R13: select releases only with the transmit queue drained
  p_ss_release_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ss_no) && ctrl_q[CTRL_HSS] && on) |-> (tx_lvl == '0) && !busy);
endmodule

// File: tb/sim_spi_fifo_master.sv
module sim_spi_fifo_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_DATA = 4'h8, A_BAUD = 4'hC;
  localparam logic [3:0] AL_CLR = 4'h1, AL_SET = 4'h2;
  localparam logic [31:0] B_ON = 32'h1 << 15, B_MST = 32'h1 << 5, B_ENH = 32'h1 << 16,
                          B_HSS = 32'h1 << 28, B_CKP = 32'h1 << 6;
  localparam int NV = 12;
  // {miso_from_clock, size, ckp, cke, smp, baud, data}
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 9'd0, 32'h000000A5},
    {1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 9'd1, 32'h0000003C},
    {1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 9'd2, 32'h0000BEEF},
    {1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 9'd0, 32'h00001234},
    {1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 9'd1, 32'hDEADBEEF},
    {1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 9'd0, 32'h80000001},
    {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 9'd0, 32'h000001FF},
    {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 9'd3, 32'hABCD1234},
    {1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 9'd0, 32'h00000000},
    {1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 9'd1, 32'h00000000},
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 9'd0, 32'h00000000},
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 9'd0, 32'h00000000}
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, miso, ss_n;
  logic miso_mode = 0, cur_ckp = 0, cnt_clr = 1, sclk_prev = 0;
  int n_chk = 0, n_fail = 0, edges = 0, ss_low = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign miso = miso_mode ? (sclk ^ cur_ckp) : mosi;

  spi_fifo_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .ss_no(ss_n)
  );

  always @(posedge clk) begin
    if (cnt_clr) begin
      edges  <= 0;
      ss_low <= 0;
    end else begin
      if (sclk !== sclk_prev) edges <= edges + 1;
      if (!ss_n) ss_low <= ss_low + 1;
    end
    sclk_prev <= sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wait_rx(input int n);
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      bus_rd(A_STAT, s);
      if (s[28:24] == 5'(n)) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] got, ctrl, mask, exp_rx;
    int nb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state: R2 R8 R13 R5
    bus_rd(A_STAT, got); chk("R8 status after reset", got, 0);
    bus_rd(A_CTRL, got); chk("R2 control after reset", got, 0);
    chk("R13 ss idle after reset", 32'(ss_n), 1);
    chk("R5 sclk idle after reset", 32'(sclk), 0);

    // R1 aliases and baud width
    bus_wr(A_CTRL, B_CKP);
    bus_wr(A_CTRL | AL_SET, 32'h100);
    bus_rd(A_CTRL, got); chk("R1 set alias", got, 32'h140);
    bus_wr(A_CTRL | AL_CLR, 32'h40);
    bus_rd(A_CTRL | AL_SET, got); chk("R1 clear alias", got, 32'h100);
    bus_wr(A_BAUD, 32'hFFFF);
    bus_rd(A_BAUD, got); chk("R1 baud width", got, 32'h1FF);

    // vector table: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      bus_wr(A_CTRL, 0);
      bus_wr(A_BAUD, 32'(v[40:32]));
      cur_ckp = v[43]; miso_mode = v[46];
      ctrl = B_ON | B_MST | B_ENH | B_HSS | (32'(v[45:44]) << 10) |
             (32'(v[43]) << 6) | (32'(v[42]) << 8) | (32'(v[41]) << 9);
      bus_wr(A_CTRL, ctrl);
      repeat (3) @(negedge clk);
      cnt_clr = 0;
      bus_wr(A_DATA, v[31:0]);
      wait_rx(1);
      repeat (2) @(negedge clk);
      nb = 8 << v[45:44];
      mask = (nb == 32) ? 32'hFFFFFFFF : ((32'h1 << nb) - 1);
      if (v[46]) exp_rx = (v[41] ? v[42] : ~v[42]) ? mask : 32'h0;
      else       exp_rx = v[31:0] & mask;
      bus_rd(A_DATA, got);
      chk(v[46] ? "R6 sample point" : "R3 loopback word", got, exp_rx);
      chk("R5 clock transitions", 32'(edges), 32'(2 * nb));
      chk("R4 select low time", 32'(ss_low), 32'(1 + 2 * nb * (int'(v[40:32]) + 1)));
      chk("R5 idle level after word", 32'(sclk), 32'(v[43]));
      cnt_clr = 1;
    end
    miso_mode = 0; cur_ckp = 0;

    // R14 R7 R9 R10: hold, capacity, order, empty read
    bus_wr(A_CTRL, 0);
    bus_wr(A_BAUD, 0);
    bus_wr(A_CTRL, B_ON | B_ENH | (32'd2 << 10));
    for (int k = 1; k <= 5; k++) bus_wr(A_DATA, 32'h11111111 * k);
    bus_rd(A_STAT, got); chk("R7 R9 tx level 32-bit full", 32'(got[20:16]), 4);
    repeat (20) @(negedge clk);
    bus_rd(A_STAT, got); chk("R14 no shifting without run", got, 32'h4 << 16);
    chk("R14 clock still idle", 32'(sclk), 0);
    bus_wr(A_CTRL | AL_SET, B_MST);
    wait_rx(4);
    for (int k = 1; k <= 4; k++) begin
      bus_rd(A_DATA, got); chk("R9 order of words", got, 32'h11111111 * k);
    end
    bus_rd(A_DATA, got); chk("R10 empty read value", got, 0);
    bus_rd(A_STAT, got); chk("R10 empty read no change", got, 0);

    // R11 overflow and R13 select off
    cnt_clr = 0;
    for (int k = 0; k < 4; k++) bus_wr(A_DATA, 32'h5A5A0000 + k);
    wait_rx(4);
    bus_wr(A_DATA, 32'h0BADF00D);
    repeat (150) @(negedge clk);
    bus_rd(A_STAT, got); chk("R11 overflow set, level kept", got, (32'h4 << 24) | 32'h40);
    chk("R13 select off stays high", 32'(ss_low), 0);
    cnt_clr = 1;
    bus_wr(A_STAT, 32'h40);
    bus_rd(A_STAT, got); chk("R11 raw write cannot clear", 32'(got[6]), 1);
    bus_wr(A_STAT | AL_CLR, 32'h40);
    bus_rd(A_STAT, got); chk("R11 clear alias clears", 32'(got[6]), 0);
    bus_rd(A_DATA, got); chk("R11 oldest word kept", got, 32'h5A5A0000);

    // R7 byte capacity, R12 flush keeps control
    bus_wr(A_CTRL, 0);
    bus_wr(A_CTRL, B_ON | B_ENH);
    for (int k = 0; k < 17; k++) bus_wr(A_DATA, k);
    bus_rd(A_STAT, got); chk("R7 8-bit capacity", 32'(got[20:16]), 16);
    bus_wr(A_CTRL, 0);
    bus_wr(A_CTRL, B_ON | B_ENH | (32'd1 << 10));
    for (int k = 0; k < 9; k++) bus_wr(A_DATA, k);
    bus_rd(A_STAT, got); chk("R7 16-bit capacity", 32'(got[20:16]), 8);
    bus_wr(A_CTRL | AL_CLR, B_ON);
    bus_rd(A_STAT, got); chk("R12 flush on disable", got, 0);
    bus_rd(A_CTRL, got); chk("R12 control preserved", got, B_ENH | (32'd1 << 10));
    bus_wr(A_CTRL, B_ON);
    for (int k = 0; k < 3; k++) bus_wr(A_DATA, k);
    bus_rd(A_STAT, got); chk("R7 shallow capacity", 32'(got[20:16]), 1);

    // R12 disable mid-word, R13 select held while shifting
    bus_wr(A_CTRL, 0);
    bus_wr(A_BAUD, 50);
    bus_wr(A_CTRL, B_ON | B_MST | B_ENH | B_HSS | B_CKP | (32'd2 << 10));
    bus_wr(A_DATA, 32'hFFFF0000);
    repeat (300) @(negedge clk);
    chk("R13 select low mid-word", 32'(ss_n), 0);
    bus_wr(A_CTRL | AL_CLR, B_ON);
    repeat (2) @(negedge clk);
    chk("R12 clock idle after disable", 32'(sclk), 1);
    chk("R12 select released", 32'(ss_n), 1);
    bus_rd(A_STAT, got); chk("R12 nothing received", got, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule